// File: doc/BRIEF.md
# Subcarrier Manchester Response Encoder

This block turns a tag's response frame into the on/off control for a load modulator. It runs on the carrier clock, fc. The caller sets two selects and pulses a start strobe. The block then emits the start-of-frame, the payload bits and the end-of-frame as a stream of subcarrier bursts and silent gaps. In single mode there is one subcarrier at fc/32. In dual mode there are two, at fc/32 and fc/28. CRC bytes are expected to be part of the supplied byte stream already.

The caller presents payload bytes one at a time on `byte_i`, together with `byte_last_i`, which marks the final byte. The encoder takes the first byte at start. It pulses `byte_ack_o` on the cycle after each byte is taken, and the caller then presents the next byte. The byte is held internally, so the input may change right after the acknowledge. `busy_o` covers the whole frame. `done_o` pulses once when the frame has finished.

Top module: `resp_sc_encoder`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `mod_o`, `busy_o`, `done_o` and `byte_ack_o` are all 0.
- R2: A `start_i` high on a clock edge while idle starts a frame. On the next cycle `busy_o` and `byte_ack_o` are 1, and the first modulation cycle appears on `mod_o`. `byte_ack_o` is a one-cycle pulse on the cycle after each byte is taken.
- R3: Single mode (`dual_sc_i`=0, taken from request flag bit b1). A 0 bit is 8 fc/32 pulses followed by 256 silent cycles. A 1 bit is 256 silent cycles followed by 8 fc/32 pulses.
- R4: Dual mode (`dual_sc_i`=1). A 0 bit is 8 fc/32 pulses followed by 9 fc/28 pulses. A 1 bit is 9 fc/28 pulses followed by 8 fc/32 pulses.
- R5: The start-of-frame is one lead-in part, then 24 fc/32 pulses, then a 1 bit. The lead-in is 768 silent cycles in single mode and 27 fc/28 pulses in dual mode.
- R6: The end-of-frame is a 0 bit, then 24 fc/32 pulses, then a tail part. The tail is 768 silent cycles in single mode and 27 fc/28 pulses in dual mode.
- R7: At the low rate (`high_rate_i`=0, taken from request flag bit b2), every pulse count and every silent length is four times its high-rate value. The subcarrier periods do not change.
- R8: Each byte is sent least significant bit first. Bytes go out in the order they are supplied. The end-of-frame follows straight after the byte that was taken with `byte_last_i`=1.
- R9: Each fc/32 pulse is 16 cycles high then 16 cycles low. Each fc/28 pulse is 14 high then 14 low. Silent parts are low. Consecutive parts follow with no gap, so every switch starts on a whole pulse.
- R10: `start_i`, `dual_sc_i` and `high_rate_i` have no effect while a frame is in progress. The selects are taken only at start.
- R11: `done_o` is high for exactly one cycle: the cycle after the last end-of-frame cycle. `busy_o` is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Carrier-rate clock (fc) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start strobe, acted on only while idle |
| dual_sc_i | input | 1 | 0 = one subcarrier, 1 = two subcarriers |
| high_rate_i | input | 1 | 0 = low data rate, 1 = high data rate |
| byte_i | input | 8 | Current payload byte |
| byte_last_i | input | 1 | Marks `byte_i` as the final payload byte |
| byte_ack_o | output | 1 | Pulse: the presented byte has been taken |
| mod_o | output | 1 | Load modulator drive |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame completion |

## Verification
Some properties hold on every cycle, and assertions check them:
- the modulator stays low while idle;
- the pulse-phase counter never leaves the current subcarrier period;
- no part is ever loaded with zero length;
- an idle start always raises busy;
- the acknowledge never appears outside a frame;
- done is a single cycle.

Other properties can only be shown by the bench scenarios. These are:
- the exact shapes of the delimiters and bits in both subcarrier modes and at both rates;
- the bit order within a byte and the order of bytes;
- the frame length;
- the fact that a start pulse sent mid-frame, with flipped selects, leaves the waveform untouched.

// File: rtl/resp_enc_pkg.sv
package resp_enc_pkg;
  typedef enum logic [1:0] {
    SEG_GAP  = 2'd0,  // unmodulated carrier
    SEG_SC_A = 2'd1,  // primary subcarrier pulses
    SEG_SC_B = 2'd2   // secondary subcarrier pulses
  } seg_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SOF  = 2'd1,
    PH_DATA = 2'd2,
    PH_EOF  = 2'd3
  } frame_ph_e;
endpackage

// File: rtl/resp_seg_timer.sv
module resp_seg_timer
  import resp_enc_pkg::*;
#(
  parameter int DIV_A = 32,
  parameter int DIV_B = 28,
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  seg_kind_e        kind_i,
  input  logic [CNT_W-1:0] pulses_i,
  output logic             mod_o,
  output logic             end_o
);
  localparam int PW = $clog2(DIV_A + 1);

  logic             active_q;
  seg_kind_e        kind_q;
  logic [PW-1:0]    cyc_q;
  logic [PW-1:0]    period;
  logic [PW-1:0]    half;
  logic [CNT_W-1:0] left_q;
  logic             last_cyc;

  // gaps are timed in units of the primary period
  always_comb begin
    period   = (kind_q == SEG_SC_B) ? PW'(DIV_B) : PW'(DIV_A);
    half     = period >> 1;
    last_cyc = (cyc_q == period - PW'(1));
  end

  assign end_o = active_q && last_cyc && (left_q == CNT_W'(1));
  assign mod_o = active_q && (kind_q != SEG_GAP) && (cyc_q < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      kind_q   <= SEG_GAP;
      cyc_q    <= '0;
      left_q   <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      kind_q   <= kind_i;
      cyc_q    <= '0;
      left_q   <= pulses_i;
    end else if (active_q) begin
      if (last_cyc) begin
        cyc_q  <= '0;
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) active_q <= 1'b0;
      end else begin
        cyc_q <= cyc_q + PW'(1);
      end
    end
  end

  a_r9_cyc_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cyc_q < period));
  a_r7_no_empty_part: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (pulses_i != '0));
endmodule

// File: rtl/resp_frame_ctl.sv
module resp_frame_ctl
  import resp_enc_pkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int SHORT_A = 8,
  parameter int SHORT_B = 9,
  parameter int LONG_A  = 24,
  parameter int LONG_B  = 27,
  parameter int LOW_MUL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dual_i,
  input  logic             high_i,
  input  logic [7:0]       byte_i,
  input  logic             last_i,
  input  logic             seg_end_i,
  output logic             load_o,
  output seg_kind_e        kind_o,
  output logic [CNT_W-1:0] pulses_o,
  output logic             ack_o,
  output logic             busy_o,
  output logic             done_o
);
  frame_ph_e  ph_q, ph_d;
  logic [1:0] idx_q, idx_d;
  logic [2:0] bitn_q, bitn_d;
  logic       half_q, half_d;
  logic [7:0] sh_q, sh_d;
  logic       last_q, last_d;
  logic       dual_q, dual_d;
  logic       high_q, high_d;
  logic       ack_q, done_q;
  logic       take, go, fin;
  logic       alt, lng;
  int         base;

  always_comb begin
    ph_d = ph_q; idx_d = idx_q; bitn_d = bitn_q; half_d = half_q;
    sh_d = sh_q; last_d = last_q; dual_d = dual_q; high_d = high_q;
    take = 1'b0; go = 1'b0; fin = 1'b0;
    if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_d = PH_SOF; idx_d = 2'd0; take = 1'b1; go = 1'b1;
        dual_d = dual_i; high_d = high_i;
      end
    end else if (seg_end_i) begin
      go = 1'b1;
      unique case (ph_q)
        PH_SOF: begin
          if (idx_q == 2'd3) begin
            ph_d = PH_DATA; bitn_d = 3'd0; half_d = 1'b0;
          end else idx_d = idx_q + 2'd1;
        end
        PH_DATA: begin
          if (!half_q) half_d = 1'b1;
          else begin
            half_d = 1'b0;
            if (bitn_q != 3'd7) begin
              bitn_d = bitn_q + 3'd1;
              sh_d   = sh_q >> 1;
            end else if (last_q) begin
              ph_d = PH_EOF; idx_d = 2'd0;
            end else begin
              bitn_d = 3'd0; take = 1'b1;
            end
          end
        end
        default: begin
          if (idx_q == 2'd3) begin
            ph_d = PH_IDLE; go = 1'b0; fin = 1'b1;
          end else idx_d = idx_q + 2'd1;
        end
      endcase
    end
    if (take) begin
      sh_d   = byte_i;
      last_d = last_i;
    end
  end

  // describe the part at the next position
  always_comb begin
    unique case (ph_d)
      PH_SOF:  begin alt = !idx_d[0];          lng = !idx_d[1]; end
      PH_EOF:  begin alt = idx_d[0];           lng = idx_d[1];  end
      PH_DATA: begin alt = sh_d[0] ^ half_d;   lng = 1'b0;      end
      default: begin alt = 1'b0;               lng = 1'b0;      end
    endcase
    kind_o = alt ? (dual_d ? SEG_SC_B : SEG_GAP) : SEG_SC_A;
    if (alt) base = lng ? (dual_d ? LONG_B : LONG_A) : (dual_d ? SHORT_B : SHORT_A);
    else     base = lng ? LONG_A : SHORT_A;
    pulses_o = high_d ? CNT_W'(base) : CNT_W'(base * LOW_MUL);
  end

  assign load_o = go;
  assign ack_o  = ack_q;
  assign done_o = done_q;
  assign busy_o = (ph_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; idx_q <= '0; bitn_q <= '0; half_q <= 1'b0;
      sh_q <= '0; last_q <= 1'b0; dual_q <= 1'b0; high_q <= 1'b0;
      ack_q <= 1'b0; done_q <= 1'b0;
    end else begin
      ph_q <= ph_d; idx_q <= idx_d; bitn_q <= bitn_d; half_q <= half_d;
      sh_q <= sh_d; last_q <= last_d; dual_q <= dual_d; high_q <= high_d;
      ack_q <= take; done_q <= fin;
    end
  end

  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r2_ack_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> busy_o);
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/resp_sc_encoder.sv
module resp_sc_encoder
  import resp_enc_pkg::*;
#(
  parameter int DIV_A   = 32,
  parameter int DIV_B   = 28,
  parameter int SHORT_A = 8,
  parameter int SHORT_B = 9,
  parameter int LONG_A  = 24,
  parameter int LONG_B  = 27,
  parameter int LOW_MUL = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       dual_sc_i,
  input  logic       high_rate_i,
  input  logic [7:0] byte_i,
  input  logic       byte_last_i,
  output logic       byte_ack_o,
  output logic       mod_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int CNT_W = $clog2(LONG_B * LOW_MUL + 1);

  logic             load;
  logic             seg_end;
  seg_kind_e        kind;
  logic [CNT_W-1:0] pulses;

  resp_frame_ctl #(
    .CNT_W(CNT_W), .SHORT_A(SHORT_A), .SHORT_B(SHORT_B),
    .LONG_A(LONG_A), .LONG_B(LONG_B), .LOW_MUL(LOW_MUL)
  ) u_ctl (
    .clk_i, .rst_ni, .start_i,
    .dual_i(dual_sc_i), .high_i(high_rate_i),
    .byte_i, .last_i(byte_last_i),
    .seg_end_i(seg_end), .load_o(load), .kind_o(kind), .pulses_o(pulses),
    .ack_o(byte_ack_o), .busy_o, .done_o
  );

  resp_seg_timer #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(load), .kind_i(kind), .pulses_i(pulses),
    .mod_o, .end_o(seg_end)
  );

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mod_o);
endmodule

// File: tb/resp_sc_encoder_bench.sv
module resp_sc_encoder_bench;
  typedef struct {
    int kind;    // 0 gap, 1 fc/32, 2 fc/28
    int pulses;
    int req;
  } seg_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       dual_sc_i = 1'b0;
  logic       high_rate_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       byte_last_i = 1'b0;
  logic       byte_ack_o, mod_o, busy_o, done_o;

  int   n_chk = 0;
  int   n_err = 0;
  seg_t q[$];
  logic [7:0] mem [0:3];
  int   nbytes = 0;
  int   bidx = 0;
  int   acks = 0;
  int   total = 0;

  always #5 clk_i = ~clk_i;

  resp_sc_encoder u_resp_sc_encoder (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input int pulses, input int req);
    seg_t s;
    s.kind = kind; s.pulses = pulses; s.req = req;
    q.push_back(s);
    total += pulses * ((kind == 2) ? 28 : 32);
  endtask

  // byte feeder: advance on acknowledge
  initial forever begin
    @(negedge clk_i); #2;
    if (byte_ack_o) begin
      acks++;
      bidx++;
      if (bidx < nbytes) begin
        byte_i = mem[bidx];
        byte_last_i = (bidx == nbytes - 1);
      end else byte_i = 8'hxx;
    end
  end

  // monitor: one check per part, R9 pulse shape included
  initial forever begin
    @(negedge clk_i); #1;
    if (q.size() > 0) begin
      seg_t s;
      int per, bad, bad_at, act0, exp0;
      bit first;
      s = q.pop_front();
      per = (s.kind == 2) ? 28 : 32;
      bad = 0; bad_at = 0; act0 = 0; exp0 = 0; first = 1'b1;
      for (int p = 0; p < s.pulses; p++) begin
        for (int c = 0; c < per; c++) begin
          logic e;
          if (!first) begin @(negedge clk_i); #1; end
          first = 1'b0;
          e = (s.kind != 0) && (c < per / 2);
          if (mod_o !== e && bad == 0) begin
            bad = 1; bad_at = p * per + c; act0 = mod_o; exp0 = e;
          end
        end
      end
      n_chk++;
      if (bad != 0) begin
        n_err++;
        $display("FAIL R%0d R9 part kind %0d x%0d at cycle %0d actual %0d expected %0d",
                 s.req, s.kind, s.pulses, bad_at, act0, exp0);
      end
    end
  end

  task automatic bit_parts(input bit b, input int altk, input int alts, input int m, input int req);
    if (b) begin push(altk, alts * m, req); push(1, 8 * m, req); end
    else   begin push(1, 8 * m, req); push(altk, alts * m, req); end
  endtask

  task automatic send_frame(input bit dual, input bit high, input int n, input bit poke);
    int m, altk, alts, altl, breq, cnt;
    m    = high ? 1 : 4;           // R7
    altk = dual ? 2 : 0;
    alts = dual ? 9 : 8;
    altl = dual ? 27 : 24;
    breq = !high ? 7 : (dual ? 4 : 3);  // R3 single, R4 dual
    nbytes = n; bidx = 0; acks = 0; total = 0;
    byte_i = mem[0]; byte_last_i = (n == 1);
    @(negedge clk_i);
    dual_sc_i = dual; high_rate_i = high; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R5 start-of-frame
    push(altk, altl * m, 5); push(1, 24 * m, 5); bit_parts(1'b1, altk, alts, m, 5);
    // R8 LSB first, bytes in order
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) bit_parts(mem[i][k], altk, alts, m, breq);
    // R6 end-of-frame
    bit_parts(1'b0, altk, alts, m, 6); push(1, 24 * m, 6); push(altk, altl * m, 6);
    #1;
    chk(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
    chk(byte_ack_o === 1'b1, "R2 first byte ack", byte_ack_o, 1);
    cnt = 0;
    while (done_o !== 1'b1 && cnt < 40000) begin
      @(negedge clk_i); #1;
      cnt++;
      if (poke && cnt == 300) begin  // R10 mid-frame start with flipped selects
        start_i = 1'b1; dual_sc_i = ~dual; high_rate_i = ~high;
      end
      if (poke && cnt == 306) begin
        start_i = 1'b0; dual_sc_i = dual; high_rate_i = high;
      end
    end
    chk(cnt == total, "R11 done cycle", cnt, total);
    chk(busy_o === 1'b0, "R11 busy low with done", busy_o, 0);
    chk(q.size() == 0, "R8 all parts emitted", q.size(), 0);
    chk(acks == n, "R8 bytes taken", acks, n);
    @(negedge clk_i); #1;
    chk(done_o === 1'b0, "R11 done one cycle", done_o, 0);
    chk(busy_o === 1'b0 && mod_o === 1'b0, poke ? "R10 no restart" : "R11 stays idle",
        {busy_o, mod_o}, 0);
  endtask

  initial begin
    #3;
    chk(mod_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1 in reset",
        {mod_o, busy_o, done_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    #1;
    chk(mod_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0 && byte_ack_o === 1'b0,
        "R1 idle after reset", {mod_o, busy_o, done_o, byte_ack_o}, 0);
    mem[0] = 8'hE1; mem[1] = 8'h3C;
    send_frame(1'b0, 1'b1, 2, 1'b1);   // R3 R10
    mem[0] = 8'hA5; mem[1] = 8'h0F; mem[2] = 8'h81;
    send_frame(1'b1, 1'b1, 3, 1'b0);   // R4
    mem[0] = 8'h6D;
    send_frame(1'b0, 1'b0, 1, 1'b0);   // R7 single
    mem[0] = 8'hB2;
    send_frame(1'b1, 1'b0, 1, 1'b0);   // R7 dual
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule